// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block manages a set of general-purpose pins grouped into banks of up to 32 pins each. Every bank carries eight 32-bit registers on a simple synchronous bus. They set pin direction, output data and open-drain drive, choose how each pin raises an interrupt event, and hold per-pin event status and an enable mask. Input pins pass through a synchronizer. Edges are then found by comparing each pin's synchronized value with its value on the previous cycle.

A pin can detect falling edges, rising edges, both edges or an active-high level. Detected events are latched in a status register that software clears by writing ones. All banks feed one combined interrupt output. That output is high while any pin has both its status bit and its mask bit set. A separate wake output pulses for one cycle whenever an event appears on an enabled pin. Bank widths are parameters, and pins at or above a bank's width are inert.

The bus uses word addressing. The upper address bits select the bank. The low three bits select the register: 0 open-drain, 1 data, 2 direction, 3 edge select, 4 both-edge, 5 mask, 6 level, 7 status. Read data appears on `bus_rdata` in the cycle after the read is sampled.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every mask and status register reads 0, every direction register reads all ones within the bank width (all pins inputs), `pin_oe` is all zero and `irq` and `wake` are low.
- R2: A pin whose direction bit is 0 drives its data-register bit on `pin_out` with `pin_oe` high. A read of the data register (index 1) returns the data-register bit for output pins and the synchronized `pin_in` value for input pins (direction bit 1).
- R3: For an output pin with its open-drain bit (index 0) set, `pin_oe` is high only while its data bit is 0.
- R4: With level (index 6), edge-select (index 3) and both-edge (index 4) bits all 0, a pin sets its status bit on a falling edge only.
- R5: With only the edge-select bit set, a pin sets its status bit on a rising edge only.
- R6: With the both-edge bit set and the level bit clear, a pin sets its status bit on every transition, whatever its edge-select bit holds.
- R7: With the level bit set, a pin sets its status bit while its synchronized input is high, and the bit sets again after a clear for as long as the input stays high.
- R8: Writing the status register (index 7) clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R9: `irq` is high exactly when some bank has a status bit and the matching mask bit (index 5) both set. A masked-off event still latches its status bit without raising `irq`.
- R10: `wake` pulses high for one cycle for each event detected on a pin whose mask bit is set, and stays low for events on masked-off pins.
- R11: Bits at or above a bank's configured width read as 0, never set status and never drive `pin_oe`.
- R12: When a status clear and a new event on the same bit fall in the same cycle, the bit stays set.
- R13: A pin change applied before clock edge k is reflected in status and `irq` after edge k+2 (two synchronizer stages plus the status register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: bank index above, register index in bits 2:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin inputs, 32 per bank |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables |
| irq | output | 1 | Combined interrupt over all banks |
| wake | output | 1 | One-cycle pulse per enabled event |

## Verification
The hardest case to reach is a status clear that lands in exactly the cycle a new event on the same bit is detected. The bench reaches it by counting edges. It toggles a both-edge pin on a falling clock edge, lets two rising edges pass through the synchronizer, and then issues the write-one-to-clear so that it is sampled on the third edge, which is the edge on which the event is latched. A long random phase draws configurations and multi-bit pin patterns from a fixed seed and compares the status and interrupt against a bench model of the detection modes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned LANES     = 32;
   localparam int unsigned REG_IDX_W = 3;
   localparam int unsigned WIDTH_FLD = 6;

   // register index order is decoded by software and kept fixed
   typedef enum logic [REG_IDX_W-1:0] {
      RG_ODRAIN = 3'd0,
      RG_DATA   = 3'd1,
      RG_DIR    = 3'd2,
      RG_EDGE   = 3'd3,
      RG_BOTH   = 3'd4,
      RG_MASK   = 3'd5,
      RG_LEVEL  = 3'd6,
      RG_STAT   = 3'd7
   } reg_sel_e;

   function automatic logic [LANES-1:0] lane_mask(input int unsigned w);
      logic [LANES-1:0] m;
      m = '0;
      for (int i = 0; i < LANES; i++)
         if (i < int'(w)) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("gpio_sync: W must be positive");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] rise_i,
   input  logic [W-1:0] both_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] evt_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise_w, fall_w, any_w;
   logic [W-1:0] edge_pick;

   gpio_sync #(.W(W), .STAGES(STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (cur_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur_o;
   end

   assign rise_w = cur_o & ~prev_q;
   assign fall_w = ~cur_o & prev_q;
   assign any_w  = cur_o ^ prev_q;

   always_comb begin
      for (int i = 0; i < W; i++) begin
         if (both_i[i])      edge_pick[i] = any_w[i];
         else if (rise_i[i]) edge_pick[i] = rise_w[i];
         else                edge_pick[i] = fall_w[i];
      end
   end

   assign evt_o = (lvl_i & cur_o) | (~lvl_i & edge_pick);

   // R4
   edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_o & ~lvl_i)) |-> (cur_o != $past(cur_o)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             wr_i,
   input  reg_sel_e         reg_i,
   input  logic [LANES-1:0] wdata_i,
   output logic [LANES-1:0] rdata_o,
   input  logic [LANES-1:0] pin_i,
   output logic [LANES-1:0] pin_out_o,
   output logic [LANES-1:0] pin_oe_o,
   output logic             irq_o,
   output logic             evt_en_o
);

   if (WIDTH < 1 || WIDTH > LANES) begin : g_bad_width
      $error("gpio_bank: WIDTH must lie in 1..32");
   end

   localparam logic [LANES-1:0] VALID = lane_mask(WIDTH);

   logic [LANES-1:0] od_q, data_q, dir_q, rise_q, both_q, mask_q, lvl_q, stat_q;
   logic [LANES-1:0] cur_w, evt_raw, evt_w, clr_w, wmask;
   logic             wr_hit, wr_stat;

   gpio_evt_detect #(.W(LANES), .STAGES(STAGES)) i_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i & VALID),
      .lvl_i  (lvl_q),
      .rise_i (rise_q),
      .both_i (both_q),
      .cur_o  (cur_w),
      .evt_o  (evt_raw)
   );

   assign evt_w   = evt_raw & VALID;
   assign wr_hit  = sel_i & wr_i;
   assign wr_stat = wr_hit & (reg_i == RG_STAT);
   assign wmask   = wdata_i & VALID;
   assign clr_w   = wr_stat ? wmask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         od_q   <= '0;
         data_q <= '0;
         dir_q  <= VALID;
         rise_q <= '0;
         both_q <= '0;
         mask_q <= '0;
         lvl_q  <= '0;
      end else if (wr_hit) begin
         unique case (reg_i)
            RG_ODRAIN: od_q   <= wmask;
            RG_DATA:   data_q <= wmask;
            RG_DIR:    dir_q  <= wmask;
            RG_EDGE:   rise_q <= wmask;
            RG_BOTH:   both_q <= wmask;
            RG_MASK:   mask_q <= wmask;
            RG_LEVEL:  lvl_q  <= wmask;
            RG_STAT:   ;
            default:   ;
         endcase
      end
   end

   // new events take priority over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_w) | evt_w;
   end

   always_comb begin
      unique case (reg_i)
         RG_ODRAIN: rdata_o = od_q;
         RG_DATA:   rdata_o = ((data_q & ~dir_q) | (cur_w & dir_q)) & VALID;
         RG_DIR:    rdata_o = dir_q;
         RG_EDGE:   rdata_o = rise_q;
         RG_BOTH:   rdata_o = both_q;
         RG_MASK:   rdata_o = mask_q;
         RG_LEVEL:  rdata_o = lvl_q;
         RG_STAT:   rdata_o = stat_q;
         default:   rdata_o = '0;
      endcase
   end

   assign pin_out_o = data_q & VALID;
   assign pin_oe_o  = ~dir_q & ~(od_q & data_q) & VALID;
   assign irq_o     = |(stat_q & mask_q);
   assign evt_en_o  = |(evt_w & mask_q);

   // R8
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((stat_q & $past(wdata_i & ~evt_w)) == '0));

   // R12
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_w) |=> ((stat_q & $past(evt_w)) == $past(evt_w)));

   // R9
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|mask_q));

   // R11
   unused_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe_o | stat_q | rdata_o) & ~VALID) == '0);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter logic [NUM_BANKS*WIDTH_FLD-1:0] BANK_WIDTHS = {6'd12, 6'd32},
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned ADDR_W     = BANK_IDX_W + REG_IDX_W,
   localparam int unsigned PINS       = NUM_BANKS * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq,
   output logic              wake
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_bank_ctrl: NUM_BANKS must be at least 1");
   end

   logic [BANK_IDX_W-1:0] bank_idx;
   reg_sel_e              reg_sel;
   logic [LANES-1:0]      bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0]  bank_irq, bank_evt;
   logic [31:0]           rd_mux;
   logic                  wake_q;

   assign bank_idx = bus_addr[ADDR_W-1:REG_IDX_W];
   assign reg_sel  = reg_sel_e'(bus_addr[REG_IDX_W-1:0]);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BW = int'(BANK_WIDTHS[b*WIDTH_FLD +: WIDTH_FLD]);
      logic hit;
      assign hit = bus_sel && (bank_idx == BANK_IDX_W'(b));

      gpio_bank #(.WIDTH(BW), .STAGES(SYNC_STAGES)) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_i     (hit),
         .wr_i      (bus_wr),
         .reg_i     (reg_sel),
         .wdata_i   (bus_wdata),
         .rdata_o   (bank_rd[b]),
         .pin_i     (pin_in[b*LANES +: LANES]),
         .pin_out_o (pin_out[b*LANES +: LANES]),
         .pin_oe_o  (pin_oe[b*LANES +: LANES]),
         .irq_o     (bank_irq[b]),
         .evt_en_o  (bank_evt[b])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (bank_idx == BANK_IDX_W'(b)) rd_mux = bank_rd[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         wake_q    <= 1'b0;
      end else begin
         if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
         wake_q <= |bank_evt;
      end
   end

   assign irq  = |bank_irq;
   assign wake = wake_q;

   // R10
   wake_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(|bank_evt));

endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] pins = '0;
   logic [63:0] pin_out, pin_oe;
   logic        irq, wake;

   int total = 0, bad = 0, wake_cnt = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_bank_ctrl i_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake));

   always @(negedge clk) if (rst_n && wake) wake_cnt++;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int bank, input int rg, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 4'(bank*8 + rg); bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int bank, input int rg, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 4'(bank*8 + rg);
      @(negedge clk);
      bus_sel = 0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [31:0] f_evt(input logic [31:0] lv, rs, bt, o, n);
      logic [31:0] e;
      for (int i = 0; i < 32; i++) begin
         if (lv[i])      e[i] = n[i];
         else if (bt[i]) e[i] = o[i] ^ n[i];
         else if (rs[i]) e[i] = n[i] & ~o[i];
         else            e[i] = o[i] & ~n[i];
      end
      return e;
   endfunction

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, lv, rs, bt, mk, exp_s, oldp, newp;
      int w0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(0, 5, r); chk("R1 mask0", r, 0);
      rd(1, 7, r); chk("R1 stat1", r, 0);
      rd(0, 2, r); chk("R1 dir0", r, 32'hFFFF_FFFF);
      chk("R1 oe", pin_oe, 0);
      chk("R1 irq", irq, 0);
      // R11 narrow bank direction reads only its width
      rd(1, 2, r); chk("R11 dir1", r, 32'h0000_0FFF);

      // R2 direction and data
      pins[31:16] = 16'h1234;
      wr(0, 2, 32'hFFFF_0000);
      wr(0, 1, 32'hFFFF_A5A5);
      chk("R2 out", pin_out[15:0], 16'hA5A5);
      chk("R2 oe", pin_oe[31:0], 32'h0000_FFFF);
      rd(0, 1, r); chk("R2 data rd", r, 32'h1234_A5A5);
      // R3 open drain
      wr(0, 0, 32'h0000_00FF);
      chk("R3 od oe", pin_oe[31:0], 32'h0000_FF5A);
      wr(0, 0, 0); wr(0, 1, 0); wr(0, 2, 32'hFFFF_FFFF);
      pins[31:16] = 0; settle();
      wr(0, 7, 32'hFFFF_FFFF);

      // R11 upper pins of narrow bank
      wr(1, 2, 0);
      chk("R11 oe1 upper", pin_oe[63:44], 0);
      wr(1, 2, 32'hFFFF_FFFF);
      pins[63:44] = '1; settle(); pins[63:44] = 0; settle();
      rd(1, 7, r); chk("R11 stat1 upper", r, 0);

      // detection modes on bank0 pins 0..3
      wr(0, 3, 32'h6); wr(0, 4, 32'h4); wr(0, 6, 32'h8);
      wr(0, 7, 32'hF);
      pins[3:0] = 4'hF; settle();
      rd(0, 7, r);
      chk("R4 fall no-set on rise", r[0], 0);
      chk("R5 rise", r[1], 1);
      chk("R6 both rise", r[2], 1);
      chk("R7 level", r[3], 1);
      wr(0, 7, 32'hF); settle();
      rd(0, 7, r); chk("R7 level re-set", r, 32'h8);
      pins[3:0] = 0; settle();
      rd(0, 7, r); chk("R4 R5 R6 falls", r, 32'hD);
      // R8 partial clear
      wr(0, 7, 32'h1);
      rd(0, 7, r); chk("R8 partial", r, 32'hC);
      wr(0, 7, 32'hC);
      rd(0, 7, r); chk("R8 full", r, 0);

      // R13 R9 R10 on bank1 pin0 rising, masked on
      wr(1, 3, 32'h1); wr(1, 5, 32'h1);
      w0 = wake_cnt;
      @(negedge clk); pins[32] = 1;
      @(negedge clk); @(negedge clk);
      chk("R13 not yet", irq, 0);
      @(negedge clk);
      chk("R13 R9 irq", irq, 1);
      settle();
      chk("R10 one pulse", wake_cnt - w0, 1);
      wr(1, 7, 32'h1);
      chk("R9 irq clear", irq, 0);
      // masked-off event: bank1 pin1 falling
      w0 = wake_cnt;
      pins[33] = 1; settle(); pins[33] = 0; settle();
      rd(1, 7, r); chk("R9 masked latched", r, 32'h2);
      chk("R9 masked no irq", irq, 0);
      chk("R10 masked no wake", wake_cnt - w0, 0);
      wr(1, 7, 32'hFFF);

      // R12 collision on bank0 pin2 (both edges)
      pins[2] = 1; settle();
      rd(0, 7, r); chk("R12 pre", r, 32'h4);
      @(negedge clk); pins[2] = 0;
      @(negedge clk);
      wr(0, 7, 32'h4);
      rd(0, 7, r); chk("R12 event wins", r, 32'h4);
      wr(0, 7, 32'h4);
      rd(0, 7, r); chk("R12 then clears", r, 0);

      // random phase on bank0
      for (int k = 0; k < 4; k++) begin
         lv = $urandom() & $urandom(); rs = $urandom(); bt = $urandom() & $urandom();
         mk = $urandom();
         wr(0, 6, lv); wr(0, 3, rs); wr(0, 4, bt); wr(0, 5, mk);
         wr(0, 7, 32'hFFFF_FFFF);
         exp_s = lv & pins[31:0];
         rd(0, 7, r); chk("R7 rand clear", r, exp_s);
         for (int j = 0; j < 25; j++) begin
            oldp = pins[31:0];
            newp = $urandom();
            pins[31:0] = newp; settle();
            exp_s = exp_s | f_evt(lv, rs, bt, oldp, newp);
            rd(0, 7, r); chk("R4 R5 R6 R7 rand stat", r, exp_s);
            chk("R9 rand irq", irq, |(exp_s & mk));
            if (j % 5 == 4) begin
               wr(0, 7, 32'hFFFF_FFFF);
               exp_s = lv & newp;
               rd(0, 7, r); chk("R8 rand clear", r, exp_s);
            end
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule